// File: doc/BRIEF.md
# Bitstream Buffer Fetch Engine

This block moves a compressed bitstream from main memory into a small on-chip byte buffer, and a downstream parser reads that buffer one byte at a time. Software gives the engine a start byte address and a byte length. Writing the length starts the transfer. The engine then issues 32-bit word reads on a request/response memory port. Bytes of the first and last words that fall outside the programmed range are dropped.

The buffer is refilled as a single burst, and only after the consumer has emptied it completely. Each burst covers the smaller of the buffer size and the bytes still owed. When the last byte of a buffer has been fetched, a sticky completion flag is set, and that flag can raise an interrupt. Software may load the next address/length pair as soon as the remaining count reads zero. This is allowed even while the last burst is still draining, so the byte stream continues without a gap in order.

Top module: `bitbuf_fetch`

## Requirements
- R1: After reset, `out_valid`, `mem_req`, `done_flag` and `irq` are low and `rem_bytes` is zero.
- R2: Host write codes on `host_sel` are as follows. Code 0 loads the start byte address. Code 1 loads the byte length and starts the transfer. Both writes are ignored while `rem_bytes` is not zero.
- R3: Each read request carries a word-aligned address (bits 1:0 zero). Only one read is outstanding at a time. `mem_req` and `mem_addr` hold steady until `mem_rdy` accepts them.
- R4: No read is requested while `out_valid` is high. Each refill fetches min(64, remaining) bytes, so once a refill has completed, `rem_bytes` equals the length minus that amount.
- R5: Bytes reach `out_byte` in ascending address order. Within a read word, byte lane k (bits 8k+7:8k) holds address word_address+k. Bytes before the start address and after start+length-1 are never delivered.
- R6: `rem_bytes` falls by exactly the number of in-range bytes taken from each read response. It never rises except through an accepted length write.
- R7: `done_flag` is set when the fetched byte count reaches the programmed length. It stays set until the host writes code 2 with data bit 0 set. A code 2 write with bit 0 clear has no effect.
- R8: `irq` is high exactly when `done_flag` is high and the interrupt enable is set. The enable is written with code 3, data bit 0.
- R9: Once every byte has been consumed and `rem_bytes` is zero, `out_valid` stays low. A new address/length pair loaded while the previous burst drains continues the stream after the last old byte.
- R10: While `out_valid` is high and `out_take` is low, `out_valid` and `out_byte` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host register write strobe |
| host_sel | input | 2 | Host write code: 0 address, 1 length, 2 status clear, 3 interrupt enable |
| host_wdata | input | ADDR_W | Host write data |
| rem_bytes | output | LEN_W | Bytes still to be fetched |
| done_flag | output | 1 | Sticky completion flag |
| irq | output | 1 | Completion interrupt |
| mem_req | output | 1 | Word read request |
| mem_rdy | input | 1 | Memory accepts the request |
| mem_addr | output | ADDR_W | Word-aligned read byte address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data word, lane 0 lowest address |
| out_valid | output | 1 | Output byte available |
| out_byte | output | 8 | Output byte |
| out_take | input | 1 | Consumer takes the byte |

## Verification
An error in the buffer pointers or byte-lane masks shows up on the very byte it touches. The scoreboard detects a duplicated, skipped or reordered byte, or a stray out-of-range byte, at the handshake where it appears. A wrong burst size or a wrong remaining count becomes visible on `rem_bytes` as soon as the first byte of a burst is offered. An early refill shows as `mem_req` asserted while `out_valid` is high, within the same cycle. A completion flag that sets at the wrong time, or that fails to stick, can be seen on `done_flag` and `irq` once the stream ends.

// File: rtl/bf_pkg.sv
package bf_pkg;
   typedef enum logic [1:0] {
      FS_IDLE,
      FS_REQ,
      FS_WAIT,
      FS_DRAIN
   } fetch_st_t;

   localparam logic [1:0] HSEL_ADDR = 2'd0;
   localparam logic [1:0] HSEL_LEN  = 2'd1;
   localparam logic [1:0] HSEL_STAT = 2'd2;
   localparam logic [1:0] HSEL_IEN  = 2'd3;

   localparam int unsigned WORD_BYTES = 4;
endpackage

// File: rtl/bf_buffer.sv
module bf_buffer #(
   parameter int unsigned DEPTH = 64,
   localparam int unsigned PW = $clog2(DEPTH + 1),
   localparam int unsigned IW = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          wr_en,
   input  logic [31:0]   wr_word,
   input  logic [1:0]    wr_off,
   input  logic [2:0]    wr_n,
   input  logic          rd_take,
   output logic [7:0]    rd_byte,
   output logic          empty
);
   logic [7:0]    mem_q [DEPTH];
   logic [PW-1:0] wr_ptr, rd_ptr;
   logic [3:0]    lane_we;
   logic [IW-1:0] lane_idx [4];

   // per-lane write enable and slot: only lanes inside [off, off+n) land
   for (genvar g = 0; g < 4; g++) begin : g_lane
      assign lane_we[g]  = wr_en && (3'(g) >= {1'b0, wr_off})
                                 && (({1'b0, wr_off} + wr_n) > 3'(g));
      assign lane_idx[g] = IW'(wr_ptr + PW'(g) - PW'(wr_off));
   end

   always_ff @(posedge clk) begin
      for (int j = 0; j < 4; j++) begin
         if (lane_we[j]) mem_q[lane_idx[j]] <= wr_word[8*j +: 8];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
      end else begin
         if (wr_en)   wr_ptr <= wr_ptr + PW'(wr_n);
         if (rd_take) rd_ptr <= rd_ptr + 1'b1;
      end
   end

   assign rd_byte = mem_q[rd_ptr[IW-1:0]];
   assign empty   = (rd_ptr == wr_ptr);
endmodule

// File: rtl/bf_fetch.sv
module bf_fetch
   import bf_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned LEN_W  = 24,
   parameter int unsigned DEPTH  = 64,
   localparam int unsigned PW = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              addr_we,
   input  logic              len_we,
   input  logic [ADDR_W-1:0] wdata,
   input  logic              mem_rdy,
   input  logic              mem_rvalid,
   input  logic              buf_empty,
   input  logic              out_take,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              buf_clr,
   output logic              buf_wr,
   output logic [1:0]        buf_off,
   output logic [2:0]        buf_n,
   output logic              rd_take,
   output logic              out_valid,
   output logic              set_done,
   output logic [LEN_W-1:0]  rem
);
   fetch_st_t         st_q;
   logic [ADDR_W-1:0] addr_q;
   logic [LEN_W-1:0]  rem_q;
   logic [PW-1:0]     blk_q;
   logic [2:0]        head, take_n;
   logic [PW-1:0]     burst_sz;
   logic              can_load, fetch_ok;

   assign head     = 3'(WORD_BYTES) - {1'b0, addr_q[1:0]};
   assign take_n   = (blk_q >= PW'(head)) ? head : blk_q[2:0];
   assign burst_sz = (rem_q > LEN_W'(DEPTH)) ? PW'(DEPTH) : PW'(rem_q);
   assign can_load = (rem_q == '0);
   assign fetch_ok = (st_q == FS_WAIT) && mem_rvalid;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= FS_IDLE;
         addr_q <= '0;
         rem_q  <= '0;
         blk_q  <= '0;
      end else begin
         case (st_q)
            FS_IDLE: if (!can_load) begin
               blk_q <= burst_sz;
               st_q  <= FS_REQ;
            end
            FS_REQ: if (mem_rdy) st_q <= FS_WAIT;
            FS_WAIT: if (mem_rvalid) begin
               blk_q <= blk_q - PW'(take_n);
               st_q  <= (blk_q == PW'(take_n)) ? FS_DRAIN : FS_REQ;
            end
            default: if (buf_empty) st_q <= FS_IDLE;
         endcase
         if (addr_we && can_load) addr_q <= wdata;
         else if (fetch_ok)       addr_q <= addr_q + ADDR_W'(take_n);
         if (len_we && can_load)  rem_q <= wdata[LEN_W-1:0];
         else if (fetch_ok)       rem_q <= rem_q - LEN_W'(take_n);
      end
   end

   assign mem_req   = (st_q == FS_REQ);
   assign mem_addr  = {addr_q[ADDR_W-1:2], 2'b00};
   assign buf_clr   = (st_q == FS_IDLE) && !can_load;
   assign buf_wr    = fetch_ok;
   assign buf_off   = addr_q[1:0];
   assign buf_n     = take_n;
   assign out_valid = (st_q == FS_DRAIN) && !buf_empty;
   assign rd_take   = out_valid && out_take;
   assign set_done  = fetch_ok && (rem_q == LEN_W'(take_n));
   assign rem       = rem_q;
endmodule

// File: rtl/bf_status.sv
module bf_status #(
   parameter bit IRQ_LEVEL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_done,
   input  logic clr_done,
   input  logic ien_we,
   input  logic ien_val,
   output logic done,
   output logic irq
);
   logic done_q, ien_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done_q <= 1'b0;
         ien_q  <= 1'b0;
      end else begin
         if (set_done)      done_q <= 1'b1;
         else if (clr_done) done_q <= 1'b0;
         if (ien_we)        ien_q  <= ien_val;
      end
   end

   if (IRQ_LEVEL) begin : g_level
      assign irq = done_q && ien_q;
   end else begin : g_pulse
      logic pulse_q;
      always_ff @(posedge clk) begin
         if (!rst_n) pulse_q <= 1'b0;
         else        pulse_q <= set_done && !done_q && ien_q;
      end
      assign irq = pulse_q;
   end

   assign done = done_q;
endmodule

// File: rtl/bitbuf_fetch.sv
module bitbuf_fetch
   import bf_pkg::*;
#(
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned LEN_W     = 24,
   parameter int unsigned DEPTH     = 64,
   parameter bit          IRQ_LEVEL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_we,
   input  logic [1:0]        host_sel,
   input  logic [ADDR_W-1:0] host_wdata,
   output logic [LEN_W-1:0]  rem_bytes,
   output logic              done_flag,
   output logic              irq,
   output logic              mem_req,
   input  logic              mem_rdy,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_rvalid,
   input  logic [31:0]       mem_rdata,
   output logic              out_valid,
   output logic [7:0]        out_byte,
   input  logic              out_take
);
   if ((DEPTH & (DEPTH - 1)) != 0 || DEPTH < WORD_BYTES) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least one word");
   end
   if (LEN_W > ADDR_W || LEN_W <= $clog2(DEPTH + 1)) begin : g_bad_len
      $error("LEN_W must fit host data and exceed the buffer size width");
   end
   if (ADDR_W < 3) begin : g_bad_addr
      $error("ADDR_W too small");
   end

   logic buf_clr, buf_wr, buf_empty, rd_take, set_done;
   logic [1:0] buf_off;
   logic [2:0] buf_n;

   bf_fetch #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .DEPTH(DEPTH)) u_fetch (
      .clk       (clk),
      .rst_n     (rst_n),
      .addr_we   (host_we && host_sel == HSEL_ADDR),
      .len_we    (host_we && host_sel == HSEL_LEN),
      .wdata     (host_wdata),
      .mem_rdy   (mem_rdy),
      .mem_rvalid(mem_rvalid),
      .buf_empty (buf_empty),
      .out_take  (out_take),
      .mem_req   (mem_req),
      .mem_addr  (mem_addr),
      .buf_clr   (buf_clr),
      .buf_wr    (buf_wr),
      .buf_off   (buf_off),
      .buf_n     (buf_n),
      .rd_take   (rd_take),
      .out_valid (out_valid),
      .set_done  (set_done),
      .rem       (rem_bytes)
   );

   bf_buffer #(.DEPTH(DEPTH)) u_buf (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (buf_clr),
      .wr_en  (buf_wr),
      .wr_word(mem_rdata),
      .wr_off (buf_off),
      .wr_n   (buf_n),
      .rd_take(rd_take),
      .rd_byte(out_byte),
      .empty  (buf_empty)
   );

   bf_status #(.IRQ_LEVEL(IRQ_LEVEL)) u_stat (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_done(set_done),
      .clr_done(host_we && host_sel == HSEL_STAT && host_wdata[0]),
      .ien_we  (host_we && host_sel == HSEL_IEN),
      .ien_val (host_wdata[0]),
      .done    (done_flag),
      .irq     (irq)
   );
endmodule

// File: rtl/bf_fetch_chk.sv
module bf_fetch_chk #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned LEN_W  = 24
) (
   input logic              clk,
   input logic              rst_n,
   input logic              host_we,
   input logic [1:0]        host_sel,
   input logic              clr_bit,
   input logic [LEN_W-1:0]  rem_bytes,
   input logic              done_flag,
   input logic              irq,
   input logic              mem_req,
   input logic              mem_rdy,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              out_valid,
   input logic [7:0]        out_byte,
   input logic              out_take
);
   AST_ALIGNED_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> mem_addr[1:0] == 2'b00); // R3
   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_rdy |=> mem_req && $stable(mem_addr)); // R3
   AST_NO_REFILL_WHILE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !mem_req); // R4
   AST_REM_NEVER_RISES: assert property (@(posedge clk) disable iff (!rst_n)
      !(host_we && host_sel == 2'd1 && rem_bytes == '0) |=> rem_bytes <= $past(rem_bytes)); // R6
   AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      done_flag && !(host_we && host_sel == 2'd2 && clr_bit) |=> done_flag); // R7
   AST_IRQ_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> done_flag); // R8
   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_take |=> out_valid && $stable(out_byte)); // R10
endmodule

bind bitbuf_fetch bf_fetch_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .host_we  (host_we),
   .host_sel (host_sel),
   .clr_bit  (host_wdata[0]),
   .rem_bytes(rem_bytes),
   .done_flag(done_flag),
   .irq      (irq),
   .mem_req  (mem_req),
   .mem_rdy  (mem_rdy),
   .mem_addr (mem_addr),
   .out_valid(out_valid),
   .out_byte (out_byte),
   .out_take (out_take)
);

// File: tb/test_bitbuf_fetch.sv
module test_bitbuf_fetch;
   localparam time CLK_PERIOD = 10ns;
   localparam int  AW = 32;
   localparam int  LW = 24;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          host_we;
   logic [1:0]    host_sel;
   logic [AW-1:0] host_wdata;
   logic [LW-1:0] rem_bytes;
   logic          done_flag, irq, mem_req, mem_rdy, mem_rvalid;
   logic [AW-1:0] mem_addr;
   logic [31:0]   mem_rdata;
   logic          out_valid, out_take;
   logic [7:0]    out_byte;

   int nchk = 0;
   int nbad = 0;
   logic [7:0] exp_q [$];

   always #(CLK_PERIOD / 2) clk = ~clk;

   bitbuf_fetch i_bitbuf_fetch (
      .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_sel(host_sel),
      .host_wdata(host_wdata), .rem_bytes(rem_bytes), .done_flag(done_flag),
      .irq(irq), .mem_req(mem_req), .mem_rdy(mem_rdy), .mem_addr(mem_addr),
      .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .out_valid(out_valid),
      .out_byte(out_byte), .out_take(out_take)
   );

   function automatic logic [7:0] mem_byte(input logic [AW-1:0] a);
      return 8'((a * 13) + (a >> 8) + 32'h5A);
   endfunction

   function automatic logic [31:0] mem_word(input logic [AW-1:0] a);
      return {mem_byte(a + 3), mem_byte(a + 2), mem_byte(a + 1), mem_byte(a)};
   endfunction

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      nchk++;
      if (!ok) begin
         nbad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic host_write(input logic [1:0] sel, input logic [AW-1:0] d);
      @(negedge clk);
      host_we = 1'b1; host_sel = sel; host_wdata = d;
      @(negedge clk);
      host_we = 1'b0;
   endtask

   // driver: pushes the expected byte stream, then programs the engine
   task automatic start_buf(input logic [AW-1:0] a, input int len);
      for (int i = 0; i < len; i++) exp_q.push_back(mem_byte(a + AW'(i)));
      host_write(2'd0, a);
      host_write(2'd1, AW'(len));
   endtask

   task automatic wait_valid();
      do @(negedge clk); while (!out_valid);
   endtask

   task automatic wait_rem_zero();
      do @(negedge clk); while (rem_bytes != '0);
   endtask

   task automatic wait_drain();
      do @(negedge clk); while (exp_q.size() != 0 || out_valid || rem_bytes != '0);
      repeat (10) @(negedge clk);
   endtask

   // memory responder, one request at a time with varying acceptance delay
   initial begin
      int gap = 0;
      logic [AW-1:0] a;
      mem_rdy = 1'b0; mem_rvalid = 1'b0; mem_rdata = '0;
      forever begin
         @(negedge clk);
         if (rst_n && mem_req) begin
            check(!out_valid, "R4 request while valid", out_valid, 0);
            check(mem_addr[1:0] == 2'b00, "R3 aligned address", mem_addr, mem_addr & ~32'h3);
            repeat (gap) @(negedge clk);
            gap = (gap + 1) % 3;
            a = mem_addr;
            mem_rdy = 1'b1;
            @(negedge clk);
            mem_rdy = 1'b0;
            mem_rvalid = 1'b1;
            mem_rdata = mem_word(a);
            @(negedge clk);
            mem_rvalid = 1'b0;
         end
      end
   end

   // consumer and scoreboard monitor
   initial begin
      int tcnt = 0;
      bit held_v = 1'b0;
      logic [7:0] held_b = '0;
      out_take = 1'b0;
      forever begin
         @(negedge clk);
         if (held_v) begin
            check(out_valid && out_byte == held_b, "R10 stalled byte held", out_byte, held_b);
            held_v = 1'b0;
         end
         tcnt++;
         out_take = (tcnt % 5) != 3;
         if (rst_n && out_valid) begin
            if (out_take) begin
               if (exp_q.size() == 0) begin
                  check(1'b0, "R5 R9 unexpected byte", out_byte, 0);
               end else begin
                  logic [7:0] e;
                  e = exp_q.pop_front();
                  check(out_byte == e, "R5 byte order", out_byte, e);
               end
            end else begin
               held_v = 1'b1;
               held_b = out_byte;
            end
         end
      end
   end

   initial begin
      repeat (60000) @(posedge clk);
      nbad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
   end

   initial begin
      rst_n = 1'b0; host_we = 1'b0; host_sel = '0; host_wdata = '0;
      repeat (5) @(negedge clk);
      check(!out_valid, "R1 out_valid", out_valid, 0);
      check(!mem_req, "R1 mem_req", mem_req, 0);
      check(rem_bytes == 0, "R1 rem_bytes", rem_bytes, 0);
      check(!done_flag, "R1 done_flag", done_flag, 0);
      check(!irq, "R1 irq", irq, 0);
      rst_n = 1'b1;

      // aligned short buffer
      start_buf(32'h40, 8);
      wait_valid();
      check(rem_bytes == 0, "R6 rem after small burst", rem_bytes, 0);
      wait_drain();
      check(done_flag, "R7 done after buffer", done_flag, 1);
      check(!irq, "R8 irq masked", irq, 0);
      check(!out_valid, "R9 idle after end", out_valid, 0);
      host_write(2'd3, 32'h1);
      check(irq, "R8 irq enabled", irq, 1);
      host_write(2'd2, 32'h1);
      check(!done_flag, "R7 W1C clear", done_flag, 0);
      check(!irq, "R8 irq follows clear", irq, 0);

      // unaligned start, multi-burst, writes while busy are ignored
      start_buf(32'h103, 100);
      host_write(2'd0, 32'h5000);
      host_write(2'd1, 32'd7);
      wait_valid();
      check(rem_bytes == 36, "R4 R6 first burst size", rem_bytes, 36);
      wait_rem_zero();
      start_buf(32'h201, 3);   // loaded while draining: R9 continuation
      wait_drain();
      check(exp_q.size() == 0 && !out_valid, "R2 R9 no extra bytes", exp_q.size(), 0);
      check(done_flag && irq, "R7 R8 done with irq", {done_flag, irq}, 2'b11);
      host_write(2'd2, 32'h0);
      check(done_flag, "R7 clear with bit0 low ignored", done_flag, 1);
      host_write(2'd2, 32'h1);
      check(!done_flag, "R7 cleared", done_flag, 0);

      // unaligned start crossing many words, then a single middle byte
      start_buf(32'h3FE, 130);
      wait_valid();
      check(rem_bytes == 66, "R4 R6 remaining after first burst", rem_bytes, 66);
      wait_rem_zero();
      start_buf(32'h302, 1);
      wait_drain();
      check(exp_q.size() == 0 && !out_valid, "R9 stream complete", exp_q.size(), 0);
      check(rem_bytes == 0, "R6 rem zero at end", rem_bytes, 0);
      check(done_flag, "R7 done after chained buffers", done_flag, 1);

      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
   end
endmodule